// File: doc/BRIEF.md
# Shadow-ROM Bank Extension Controller

This block sits next to an 8-bit processor bus with a 16-bit address and widens the reach of data accesses to 20 bits, as sixteen 64K banks. A shadow ROM is addressed in parallel with program memory. Its byte is sampled on the clock edge that closes an opcode-fetch cycle. That byte then steers the upper address lines and a set of peripheral selects during data-access cycles of the same instruction.

Two status pins classify every bus cycle. Both high is an opcode fetch. Program-valid alone is an operand fetch. Data-valid alone is a data access. Neither is an internal cycle. Only on a data access are the upper address bits taken from the bank source and a peripheral select asserted. On all other cycles the upper bits are zero, so code, zero page, stack and I/O stay in bank 0. The latched byte carries three things. Its low four bits hold a static bank number. Bit 4 chooses the static bank or a 4-bit dynamic bank register, which the processor writes as an I/O location. Bits 7..5 hold a peripheral field.

Software that uses an indirect mode or the stack must leave the bank bits zero for that opcode, because those cycles also show the data-access status.

Top module: `shadow_bank_ext`

## Requirements
- R1: After synchronous reset, the latched shadow byte and the dynamic bank register are 0, so a data cycle drives `ext_addr` = 0 and all `per_sel_n` high.
- R2: On a cycle with `vpa`=1 and `vda`=1, the shadow byte is captured on the rising clock edge that ends the cycle, and `ext_addr` is 0 during that fetch cycle.
- R3: On a data cycle (`vpa`=0, `vda`=1) with latched bit 4 = 0, `ext_addr` equals latched bits 3..0.
- R4: On every cycle that is not a data cycle (status pairs 1/1, 1/0, 0/0), `ext_addr` is 0 and all `per_sel_n` are high.
- R5: On a data cycle with latched bit 4 = 1, `ext_addr` equals the dynamic bank register.
- R6: The dynamic bank register loads `cpu_data[3:0]` on the rising edge that ends a data cycle with `rw`=0, `cpu_addr` equal to `DYN_ADDR` (default 16'hFE00) and an effective bank of 0.
- R7: A cycle that is a read, is not a data cycle, or has a nonzero effective bank leaves the dynamic register unchanged, even at `DYN_ADDR`.
- R8: On a data cycle, latched field bits 7..5 = f with f ≠ 0 drive `per_sel_n[f-1]` low and all other selects high. f = 0 asserts no select.
- R9: Operand-fetch, internal and data cycles do not change the latched byte. A four-cycle absolute access (fetch, two operands, data) uses the bank captured at its fetch, on its last cycle only.
- R10: Each new opcode fetch replaces the latched byte. A later fetch with bank bits 0 returns data cycles to bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | Processor address bus |
| vpa | input | 1 | Program-address-valid status |
| vda | input | 1 | Data-address-valid status |
| rw | input | 1 | 1 = read, 0 = write |
| cpu_data | input | 8 | Processor data bus, used for dynamic bank writes |
| shadow_byte | input | 8 | Shadow ROM byte at the current address |
| ext_addr | output | 4 | Upper address bits 19..16 |
| per_sel_n | output | 7 | Active-low peripheral selects, index f-1 for field f |

## Verification
The hardest case is the dynamic bank register's write qualifier. A write reaches it only when the effective bank is already 0. A program therefore has to load the register under a static bank-0 opcode, switch to the dynamic source with a fresh fetch, and then try writes that must be refused. These are writes under a nonzero dynamic bank, reads at the register address, and writes shown on operand cycles. Each refusal is seen through the register's value on the next dynamic-source data cycle. The peripheral field is swept through all eight codes, each behind its own opcode fetch.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  // Bus cycle kind, encoded as {vpa, vda}
  typedef enum logic [1:0] {
    CYC_IDLE    = 2'b00,
    CYC_DATA    = 2'b01,
    CYC_OPERAND = 2'b10,
    CYC_OPCODE  = 2'b11
  } cyc_kind_t;
endpackage

// File: rtl/sbx_cycle_class.sv
module sbx_cycle_class
  import sbx_pkg::*;
(
  input  logic      vpa,
  input  logic      vda,
  output cyc_kind_t kind,
  output logic      is_fetch,
  output logic      is_data
);
  always_comb begin
    kind     = cyc_kind_t'({vpa, vda});
    is_fetch = (kind == CYC_OPCODE);
    is_data  = (kind == CYC_DATA);
  end
endmodule

// File: rtl/sbx_bank_state.sv
module sbx_bank_state #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch,
  input  logic [DATA_W-1:0] shadow_in,
  input  logic              wr_hit,
  input  logic [BANK_W-1:0] wr_bank,
  output logic [DATA_W-1:0] shadow_q,
  output logic [BANK_W-1:0] dyn_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      dyn_q    <= '0;
    end else begin
      if (fetch)  shadow_q <= shadow_in;
      if (wr_hit) dyn_q    <= wr_bank;
    end
  end

  // R2: an opcode fetch captures the shadow byte
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    fetch |=> shadow_q == $past(shadow_in));
  // R9: no other cycle disturbs the latched byte
  p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !fetch |=> $stable(shadow_q));
  // R7: the dynamic register moves only on a qualified write
  p_dyn_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(dyn_q));
endmodule

// File: rtl/sbx_sel_decode.sv
module sbx_sel_decode #(
  parameter int SEL_W = 3,
  localparam int NSEL = (1 << SEL_W) - 1
) (
  input  logic             en,
  input  logic [SEL_W-1:0] field,
  output logic [NSEL-1:0]  sel_n
);
  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign sel_n[g] = !(en && (field == SEL_W'(g + 1)));
  end

  // R8: never more than one select active
  always_comb begin
    a_onehot_r8: assert ($onehot0(~sel_n));
  end
endmodule

// File: rtl/shadow_bank_ext.sv
module shadow_bank_ext
  import sbx_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          BANK_W   = 4,
  parameter int          SEL_W    = 3,
  parameter logic [15:0] DYN_ADDR = 16'hFE00,
  localparam int NSEL    = (1 << SEL_W) - 1,
  localparam int SRC_BIT = BANK_W,
  localparam int FLD_LSB = BANK_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              vpa,
  input  logic              vda,
  input  logic              rw,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic [DATA_W-1:0] shadow_byte,
  output logic [BANK_W-1:0] ext_addr,
  output logic [NSEL-1:0]   per_sel_n
);
  cyc_kind_t         kind;
  logic              is_fetch, is_data, wr_hit;
  logic [DATA_W-1:0] shadow_q;
  logic [BANK_W-1:0] dyn_q, bank_eff;

  sbx_cycle_class i_class (
    .vpa(vpa), .vda(vda), .kind(kind),
    .is_fetch(is_fetch), .is_data(is_data)
  );

  sbx_bank_state #(.DATA_W(DATA_W), .BANK_W(BANK_W)) i_state (
    .clk(clk), .rst(rst), .fetch(is_fetch), .shadow_in(shadow_byte),
    .wr_hit(wr_hit), .wr_bank(cpu_data[BANK_W-1:0]),
    .shadow_q(shadow_q), .dyn_q(dyn_q)
  );

  always_comb begin
    bank_eff = shadow_q[SRC_BIT] ? dyn_q : shadow_q[BANK_W-1:0];
    ext_addr = is_data ? bank_eff : '0;
    wr_hit   = is_data && !rw && (cpu_addr == ADDR_W'(DYN_ADDR))
               && (bank_eff == '0);
  end

  sbx_sel_decode #(.SEL_W(SEL_W)) i_dec (
    .en(is_data), .field(shadow_q[FLD_LSB +: SEL_W]), .sel_n(per_sel_n)
  );

  // R4: outside data cycles the upper bits are zero and no select is active
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !(vda && !vpa) |-> (ext_addr == '0) && (&per_sel_n));
  // R2: the fetch cycle itself stays in bank 0
  p_fetch_bank0_r2: assert property (@(posedge clk) disable iff (rst)
    (vpa && vda) |-> ext_addr == '0);
  // R1: the cycle after reset shows no bank and no select
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (dyn_q == '0) && (shadow_q == '0));
endmodule

// File: tb/test_shadow_bank_ext.sv
module test_shadow_bank_ext;
  localparam int NSEL = 7;

  typedef struct {
    logic [3:0]      ext;
    logic [NSEL-1:0] sel;
    string           tag;
  } item_t;

  logic       clk = 0, rst = 1;
  logic [15:0] cpu_addr = '0;
  logic       vpa = 0, vda = 0, rw = 1;
  logic [7:0] cpu_data = '0, shadow_byte = '0;
  logic [3:0] ext_addr;
  logic [NSEL-1:0] per_sel_n;

  int total = 0, bad = 0;
  item_t sb[$];
  logic [7:0] m_latch = '0;
  logic [3:0] m_dyn = '0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  shadow_bank_ext i_shadow_bank_ext (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .vpa(vpa), .vda(vda),
    .rw(rw), .cpu_data(cpu_data), .shadow_byte(shadow_byte),
    .ext_addr(ext_addr), .per_sel_n(per_sel_n)
  );

  // Monitor: compares each cycle's outputs against the queued expectation
  always @(negedge clk) begin
    #5;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (ext_addr !== it.ext || per_sel_n !== it.sel) begin
        bad++;
        $display("FAIL %s: ext=%h sel=%b expected ext=%h sel=%b",
                 it.tag, ext_addr, per_sel_n, it.ext, it.sel);
      end
    end
  end

  // Driver: one bus cycle, with the expectation taken from the spec model
  task automatic cyc(input logic p, input logic d, input logic r,
                     input logic [15:0] a, input logic [7:0] dat,
                     input logic [7:0] sh, input string tag);
    item_t it;
    logic data_c;
    logic [3:0] bank;
    logic [2:0] f;
    @(negedge clk);
    vpa = p; vda = d; rw = r; cpu_addr = a; cpu_data = dat; shadow_byte = sh;
    data_c = d && !p;
    bank = m_latch[4] ? m_dyn : m_latch[3:0];
    f = m_latch[7:5];
    it.ext = data_c ? bank : 4'h0;
    it.sel = '1;
    if (data_c && f != 0) it.sel[f-1] = 1'b0;
    it.tag = tag;
    sb.push_back(it);
    // state update at the closing edge
    if (p && d) m_latch = sh;
    if (data_c && !r && a == 16'hFE00 && bank == 4'h0) m_dyn = dat[3:0];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state seen on a data cycle
    cyc(0, 1, 1, 16'h1234, 8'h00, 8'hFF, "R1 reset data cycle");
    // R2, R3, R9: absolute access fetch/operand/operand/data
    cyc(1, 1, 1, 16'h0200, 8'h00, 8'h03, "R2 fetch bank0");
    cyc(1, 0, 1, 16'h0201, 8'h00, 8'hFF, "R9 operand");
    cyc(1, 0, 1, 16'h0202, 8'h00, 8'h7E, "R9 operand");
    cyc(0, 1, 1, 16'h1234, 8'h00, 8'hFF, "R3 data static bank 3");
    cyc(0, 0, 1, 16'h1234, 8'h00, 8'hFF, "R4 internal");
    cyc(0, 1, 0, 16'h1235, 8'h00, 8'h00, "R9 second data cycle holds");
    // R8 with bank 5 field 5
    cyc(1, 1, 1, 16'h0203, 8'h00, 8'hA5, "R2 fetch");
    cyc(1, 0, 1, 16'h0204, 8'h00, 8'h00, "R4 operand no select");
    cyc(0, 1, 1, 16'h4000, 8'h00, 8'h00, "R8 field5 bank5");
    // R6 load dynamic register under bank 0
    cyc(1, 1, 1, 16'h0205, 8'h00, 8'h00, "R10 fetch bank0");
    cyc(0, 1, 0, 16'hFE00, 8'h09, 8'h00, "R6 write dyn");
    cyc(1, 1, 1, 16'h0206, 8'h00, 8'h10, "R2 fetch dyn source");
    cyc(0, 1, 1, 16'h3000, 8'h00, 8'h00, "R5 dyn bank 9");
    // R7 refused writes
    cyc(0, 1, 0, 16'hFE00, 8'h02, 8'h00, "R7 write nonzero bank");
    cyc(0, 1, 1, 16'h3001, 8'h00, 8'h00, "R7 dyn still 9");
    cyc(1, 1, 1, 16'h0207, 8'h00, 8'h00, "R10 fetch bank0");
    cyc(0, 1, 1, 16'hFE00, 8'h04, 8'h00, "R7 read at reg");
    cyc(1, 0, 0, 16'hFE00, 8'h06, 8'h00, "R7 operand write");
    cyc(0, 0, 0, 16'hFE00, 8'h07, 8'h00, "R7 internal write");
    cyc(0, 1, 0, 16'hFE01, 8'h05, 8'h00, "R7 other addr");
    cyc(1, 1, 1, 16'h0208, 8'h00, 8'h10, "R2 fetch dyn");
    cyc(0, 1, 1, 16'h3002, 8'h00, 8'h00, "R7 dyn unchanged 9");
    // R10 return to bank 0
    cyc(1, 1, 1, 16'h0209, 8'h00, 8'h00, "R10 fetch");
    cyc(0, 1, 1, 16'h3003, 8'h00, 8'h00, "R10 bank0 again");
    // R8 sweep of every field code
    for (int f = 0; f < 8; f++) begin
      cyc(1, 1, 1, 16'h0300, 8'h00, {f[2:0], 1'b0, 4'(f + 8)}, "R8 sweep fetch");
      cyc(0, 1, 1, 16'h5000, 8'h00, 8'h00, "R8 sweep data");
    end
    cyc(0, 0, 1, 16'h0000, 8'h00, 8'h00, "R4 idle");
    @(negedge clk);
    #8;
    done = 1;
  end

  initial begin
    wait (done);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule